// File: doc/BRIEF.md
# Time-Over-Threshold Transition Capture Multiplexer

This block sits behind eight front-end channels. Each channel supplies two discriminator levels: one from a low-threshold comparator and one from a high-threshold comparator. The block brings both levels into its clock domain and scans the channels in turn, one per clock. At each visit it compares the current samples with those taken on that channel's previous visit. Every transition it finds becomes a record carrying the channel, which comparator changed, the direction of the change and a coarse event time. Records enter a small FIFO, and a valid/ready port drains it.

The event time advances once per complete scan of the channels. With the fast clock at 50 ns and eight channels, one time unit is therefore 400 ns. A downstream consumer rebuilds each pulse's time over threshold by subtracting the leading time from the trailing time. The low comparator gates the high comparator. High-comparator transitions are kept only while the channel's low comparator is high, so each high-threshold pulse is framed by its low-threshold envelope. There is no trigger and no digital dead time: a channel is ready for a new pulse as soon as its previous trailing edge has been seen.

Top module: `tot_edge_mux`

## Requirements
- R1: While reset is held and directly after it, `rd_valid` and `overflow` are 0.
- R2: A record is 17 bits: bits [16:14] channel index, bit 13 comparator (0 low, 1 high), bit 12 edge (1 leading/rising, 0 trailing/falling), bits [11:0] event time.
- R3: A rising low-comparator input produces one low/leading record, and the matching fall produces one low/trailing record.
- R4: A high-comparator transition is recorded only at a visit where the previous or the current low sample of that channel is high. High transitions while the low input stays low produce no record.
- R5: When both comparators of one channel change at the same visit, the low record is queued before the high record, and both carry the same event time.
- R6: For a low pulse lasting W event-time units, trailing time minus leading time, taken modulo 4096, equals W to within one unit. This also holds when the event-time counter wraps during the pulse.
- R7: A channel re-arms immediately. A new low pulse that starts one unit after the previous trailing edge yields its own leading and trailing records.
- R8: Each channel is visited once every 8 clocks, and the event time advances once per scan. Pulses that start together on two channels are both recorded, with event times no more than one unit apart.
- R9: The FIFO holds 16 records and returns them in arrival order. `rd_data` stays stable while `rd_valid` is high and `rd_ready` is low.
- R10: When the FIFO is full, new records are dropped and the older contents are kept. `overflow` is then set and stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock, one channel slot per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| lo_cmp | input | 8 | Low-threshold discriminator level per channel (asynchronous) |
| hi_cmp | input | 8 | High-threshold discriminator level per channel (asynchronous) |
| rd_valid | output | 1 | FIFO holds a record |
| rd_ready | input | 1 | Consumer takes the head record on this cycle |
| rd_data | output | 17 | Head record: channel, comparator, edge, event time |
| overflow | output | 1 | Sticky flag: a record was dropped because the FIFO was full |

## Verification
The bench goes after the gating window. A high pulse on a channel whose low input is idle must leave no trace. A high input that is already high when the low window opens must yield only its trailing record; a design that gates on the wrong sample would either drop that record or invent a leading one. Simultaneous low and high changes check that the records keep their order and share one time stamp. A pulse that straddles the 4096 wrap would show a huge width in a design that compares times without wrapping. A back-to-back re-arm would catch any hidden hold-off. Filling the FIFO with the port stalled shows whether a design drops the newest records rather than overwriting the oldest, and whether its flag really stays set after the FIFO has been drained.

// File: rtl/tot_edge_mux.sv
module tot_edge_mux #(
  parameter int NCH   = 8,
  parameter int TW    = 12,
  parameter int DEPTH = 16
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [NCH-1:0]                        lo_cmp,
  input  logic [NCH-1:0]                        hi_cmp,
  output logic                                  rd_valid,
  input  logic                                  rd_ready,
  output logic [$clog2(NCH)+2+TW-1:0]           rd_data,
  output logic                                  overflow
);
  localparam int CHW = $clog2(NCH);
  localparam int RW  = CHW + 2 + TW;
  localparam int AW  = $clog2(DEPTH);
  localparam int CW  = AW + 1;

  logic [NCH-1:0] lo_m, lo_s, hi_m, hi_s;
  logic [NCH-1:0] lo_prev, hi_prev;
  logic [CHW-1:0] slot;
  logic [TW-1:0]  tnow;
  logic [RW-1:0]  mem [DEPTH];
  logic [AW-1:0]  wp, rp;
  logic [CW-1:0]  cnt;

  wire lo_now = lo_s[slot];
  wire hi_now = hi_s[slot];
  wire lo_was = lo_prev[slot];
  wire hi_was = hi_prev[slot];

  wire want_lo = lo_now ^ lo_was;
  wire want_hi = (hi_now ^ hi_was) & (lo_now | lo_was);

  wire [RW-1:0] lo_rec = {slot, 1'b0, lo_now, tnow};
  wire [RW-1:0] hi_rec = {slot, 1'b1, hi_now, tnow};

  wire [CW-1:0] room   = CW'(DEPTH) - cnt;
  wire          acc_lo = want_lo && (room != '0);
  wire          acc_hi = want_hi && (room > (acc_lo ? CW'(1) : CW'(0)));
  wire          drop   = (want_lo && !acc_lo) || (want_hi && !acc_hi);
  wire          pop    = rd_valid && rd_ready;

  assign rd_valid = (cnt != '0);
  assign rd_data  = mem[rp];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_m <= '0; lo_s <= '0; hi_m <= '0; hi_s <= '0;
    end else begin
      lo_m <= lo_cmp; lo_s <= lo_m;
      hi_m <= hi_cmp; hi_s <= hi_m;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot    <= '0;
      tnow    <= '0;
      lo_prev <= '0;
      hi_prev <= '0;
    end else begin
      lo_prev[slot] <= lo_now;
      hi_prev[slot] <= hi_now;
      if (slot == CHW'(NCH - 1)) begin
        slot <= '0;
        tnow <= tnow + 1'b1;
      end else begin
        slot <= slot + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (acc_lo) mem[wp] <= lo_rec;
    if (acc_hi) mem[wp + AW'(acc_lo)] <= hi_rec;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp       <= '0;
      rp       <= '0;
      cnt      <= '0;
      overflow <= 1'b0;
    end else begin
      wp  <= wp + AW'(acc_lo) + AW'(acc_hi);
      rp  <= rp + AW'(pop);
      cnt <= cnt + CW'(acc_lo) + CW'(acc_hi) - CW'(pop);
      if (drop) overflow <= 1'b1;
    end
  end
endmodule

// File: rtl/tot_edge_mux_chk.sv
module tot_edge_mux_chk #(
  parameter int NCH   = 8,
  parameter int TW    = 12,
  parameter int DEPTH = 16
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          rd_valid,
  input logic                          rd_ready,
  input logic [$clog2(NCH)+2+TW-1:0]   rd_data,
  input logic                          overflow,
  input logic [$clog2(DEPTH):0]        cnt,
  input logic [$clog2(NCH)-1:0]        slot,
  input logic [TW-1:0]                 tnow
);
  localparam int CHW = $clog2(NCH);
  localparam int CW  = $clog2(DEPTH) + 1;

  // R10
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  // R10
  overflow_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !overflow |=> (!overflow || $past(cnt) >= CW'(DEPTH - 1)));

  // R9
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  // R9
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

  // R8
  slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot != CHW'(NCH - 1)) |=> (slot == $past(slot) + 1'b1) && $stable(tnow));

  // R8
  time_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot == CHW'(NCH - 1)) |=> (slot == '0) && (tnow == $past(tnow) + 1'b1));
endmodule

bind tot_edge_mux tot_edge_mux_chk #(.NCH(NCH), .TW(TW), .DEPTH(DEPTH)) chk (
  .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_ready(rd_ready),
  .rd_data(rd_data), .overflow(overflow), .cnt(cnt), .slot(slot), .tnow(tnow)
);

// File: tb/tot_edge_mux_test.sv
module tot_edge_mux_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  lo = '0, hi = '0;
  logic        rd_ready = 1'b1;
  logic        rd_valid, overflow;
  logic [16:0] rd_data;

  always #5 clk = ~clk;

  tot_edge_mux uut (
    .clk(clk), .rst_n(rst_n), .lo_cmp(lo), .hi_cmp(hi),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data), .overflow(overflow)
  );

  int checks = 0, errors = 0;
  logic [16:0] recs [64];
  int nrec = 0;

  always @(negedge clk)
    if (rst_n && rd_valid && rd_ready && nrec < 64) begin
      recs[nrec] = rd_data;
      nrec = nrec + 1;
    end

  // fields [27:25] ch, [24:17] width, [16] high pulse on, [15:8] high delay, [7:0] high width
  localparam logic [27:0] VEC [5] = '{
    {3'd0, 8'd6,  1'b1, 8'd2, 8'd2},
    {3'd7, 8'd3,  1'b0, 8'd0, 8'd0},
    {3'd3, 8'd10, 1'b1, 8'd1, 8'd7},
    {3'd1, 8'd2,  1'b0, 8'd0, 8'd0},
    {3'd5, 8'd12, 1'b1, 8'd4, 8'd3}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic ticks(input int n);
    cyc(n * 8);
  endtask

  task automatic do_reset;
    rst_n = 1'b0; lo = '0; hi = '0;
    cyc(3);
    rst_n = 1'b1;
    nrec = 0;
  endtask

  function automatic int hdr(input logic [16:0] r);
    return {r[16:14], r[13], r[12]};
  endfunction

  function automatic int tdiff(input logic [16:0] a, input logic [16:0] b);
    logic [11:0] d;
    d = b[11:0] - a[11:0];
    return int'(d);
  endfunction

  function automatic bit near(input int d, input int w);
    return (d >= w - 1) && (d <= w + 1);
  endfunction

  task automatic chkrec(input int i, input int ch, input int cmp, input int edg, input string tag);
    chk(hdr(recs[i]) == ((ch << 2) | (cmp << 1) | edg), tag, hdr(recs[i]), (ch << 2) | (cmp << 1) | edg);
  endtask

  initial begin
    #2000000;
    checks++; errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1;
    cyc(2);
    chk(rd_valid == 1'b0, "R1 valid in reset", rd_valid, 0);
    chk(overflow == 1'b0, "R1 overflow in reset", overflow, 0);
    rst_n = 1'b1;
    ticks(2);
    chk(rd_valid == 1'b0, "R1 valid after reset", rd_valid, 0);

    // R2 R3 R6: table of pulses
    for (int v = 0; v < 5; v++) begin
      int ch, w, hd, hw, n;
      bit hon;
      ch = VEC[v][27:25]; w = VEC[v][24:17]; hon = VEC[v][16];
      hd = VEC[v][15:8];  hw = VEC[v][7:0];
      n = hon ? 4 : 2;
      nrec = 0;
      lo[ch] = 1'b1;
      if (hon) begin
        ticks(hd); hi[ch] = 1'b1;
        ticks(hw); hi[ch] = 1'b0;
        ticks(w - hd - hw);
      end else begin
        ticks(w);
      end
      lo[ch] = 1'b0;
      ticks(3);
      chk(nrec == n, "R3 record count", nrec, n);
      if (nrec == n) begin
        chkrec(0, ch, 0, 1, "R2 R3 low leading");
        chkrec(n - 1, ch, 0, 0, "R2 R3 low trailing");
        chk(near(tdiff(recs[0], recs[n-1]), w), "R6 low width", tdiff(recs[0], recs[n-1]), w);
        if (hon) begin
          chkrec(1, ch, 1, 1, "R4 high leading");
          chkrec(2, ch, 1, 0, "R4 high trailing");
          chk(near(tdiff(recs[1], recs[2]), hw), "R6 high width", tdiff(recs[1], recs[2]), hw);
          chk(near(tdiff(recs[0], recs[1]), hd), "R6 high delay", tdiff(recs[0], recs[1]), hd);
        end
      end
    end

    // R4: high pulse with low idle is ignored
    nrec = 0;
    hi[1] = 1'b1; ticks(3); hi[1] = 1'b0; ticks(3);
    chk(nrec == 0 && !rd_valid, "R4 closed window ignored", nrec, 0);

    // R4: high already high when window opens -> only its trailing edge
    nrec = 0;
    hi[2] = 1'b1; ticks(2);
    lo[2] = 1'b1; ticks(2);
    hi[2] = 1'b0; ticks(2);
    lo[2] = 1'b0; ticks(3);
    chk(nrec == 3, "R4 late window count", nrec, 3);
    if (nrec == 3) begin
      chkrec(0, 2, 0, 1, "R4 late window lead");
      chkrec(1, 2, 1, 0, "R4 late window high trail");
      chkrec(2, 2, 0, 0, "R4 late window trail");
    end

    // R5: both comparators at the same visit
    nrec = 0;
    lo[6] = 1'b1; hi[6] = 1'b1; ticks(4);
    lo[6] = 1'b0; hi[6] = 1'b0; ticks(3);
    chk(nrec == 4, "R5 count", nrec, 4);
    if (nrec == 4) begin
      chkrec(0, 6, 0, 1, "R5 low first on rise");
      chkrec(1, 6, 1, 1, "R5 high second on rise");
      chk(recs[0][11:0] == recs[1][11:0], "R5 same time rise", recs[1][11:0], recs[0][11:0]);
      chkrec(2, 6, 0, 0, "R5 low first on fall");
      chkrec(3, 6, 1, 0, "R5 high second on fall");
    end

    // R7: re-arm one unit after trailing
    nrec = 0;
    lo[4] = 1'b1; ticks(3); lo[4] = 1'b0; ticks(1);
    lo[4] = 1'b1; ticks(2); lo[4] = 1'b0; ticks(3);
    chk(nrec == 4, "R7 re-arm count", nrec, 4);
    if (nrec == 4) begin
      chkrec(2, 4, 0, 1, "R7 second leading");
      chkrec(3, 4, 0, 0, "R7 second trailing");
      chk(near(tdiff(recs[2], recs[3]), 2), "R7 second width", tdiff(recs[2], recs[3]), 2);
      chk(near(tdiff(recs[1], recs[2]), 1), "R7 gap", tdiff(recs[1], recs[2]), 1);
    end

    // R8: two channels together
    nrec = 0;
    lo[2] = 1'b1; lo[5] = 1'b1; ticks(4);
    lo[2] = 1'b0; lo[5] = 1'b0; ticks(3);
    chk(nrec == 4, "R8 count", nrec, 4);
    if (nrec == 4) begin
      int c0, c1;
      c0 = recs[0][16:14]; c1 = recs[1][16:14];
      chk((c0 == 2 && c1 == 5) || (c0 == 5 && c1 == 2), "R8 both channels", c0 * 8 + c1, 21);
      chk(near(tdiff(recs[0], recs[1]), 0), "R8 time spread", tdiff(recs[0], recs[1]), 0);
    end

    // R6: pulse across the counter wrap
    do_reset;
    ticks(4085);
    lo[0] = 1'b1; ticks(20); lo[0] = 1'b0; ticks(3);
    chk(nrec == 2, "R6 wrap count", nrec, 2);
    if (nrec == 2) begin
      chk(recs[1][11:0] < recs[0][11:0], "R6 wrap occurred", recs[1][11:0], recs[0][11:0]);
      chk(near(tdiff(recs[0], recs[1]), 20), "R6 wrap width", tdiff(recs[0], recs[1]), 20);
    end

    // R9 R10: fill with port stalled
    do_reset;
    rd_ready = 1'b0;
    for (int p = 0; p < 9; p++) begin
      lo[3] = 1'b1; ticks(2); lo[3] = 1'b0; ticks(2);
    end
    ticks(1);
    chk(overflow == 1'b1, "R10 overflow set", overflow, 1);
    begin
      logic [16:0] held;
      held = rd_data;
      cyc(5);
      chk(rd_valid && rd_data == held, "R9 data held", rd_data, held);
    end
    nrec = 0;
    rd_ready = 1'b1;
    ticks(4);
    chk(nrec == 16, "R9 R10 depth", nrec, 16);
    if (nrec == 16) begin
      chkrec(0, 3, 0, 1, "R9 oldest first");
      chkrec(15, 3, 0, 0, "R10 newest dropped");
      chk(near(tdiff(recs[14], recs[15]), 2), "R9 order kept", tdiff(recs[14], recs[15]), 2);
    end
    chk(overflow == 1'b1 && !rd_valid, "R10 sticky after drain", overflow, 1);
    do_reset;
    chk(overflow == 1'b0, "R10 cleared by reset", overflow, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule